// File: doc/BRIEF.md
# Byte-Wide Host Register Port for a 24-Bit Counter

This block is the host side of a 24-bit event counter. An 8-bit processor bus reaches it through active-low chip select, read and write strobes, plus a control/data select. In control space, a write is steered by its two top data bits to one of four control registers, and a read returns a status byte built from the counter's flags. In data space, writes fill a 24-bit preset one byte at a time and reads drain a 24-bit snapshot latch one byte at a time. A single byte pointer serves both directions.

All bus and pin inputs first pass through a synchronizer chain. A bus access is recognized on the falling edge of its strobe while chip select is low. Master-control writes are commands that take effect once and need no clearing write afterwards. Some of them act on the counter itself, which lives outside this block. For those, the block issues one-cycle pulses and reads back the counter value and flags as inputs. Two active-low pins give hardware control. The first loads the counter from the preset or snapshots the counter into the latch. The second resets the counter or gates counting.

Top module: `cnt_host_if`

## Requirements
- R1: After reset the preset reads FFFFFF, all control registers are zero, the byte pointer is 0, `dout_oe` is low and no command pulse is active.
- R2: A control write (`cd_sel`=1) is routed by data bits 7:6. 00 is master control. 01 stores bits 5:0 into the input register `icr_q`. 10 stores bits 5:0 into the output register `occr_q`. 11 stores bits 1:0 into `qr_q`. The other control registers keep their values.
- R3: A data write (`cd_sel`=0) stores the byte into preset byte 0, 1 or 2 (byte 0 = bits 7:0) at the pointer, then advances the pointer. The pointer wraps from 2 back to 0.
- R4: A data read returns the latch byte at the same shared pointer, then advances the pointer with the same wrap.
- R5: A control read returns {000, direction, sign, compare toggle, carry toggle, borrow toggle}, with the flags taken from `cnt_flags[4:0]` and the borrow toggle at bit 0.
- R6: Master-control bits act as one-shot commands. Bit 0 resets the pointer. Bit 1 copies `cnt_value` into the latch. Bit 2 gives one `cnt_clear` pulse. Bit 3 gives one `cnt_load` pulse. Bit 4 gives one `cmp_clear` pulse.
- R7: Several master-control bits set in one write all take effect from that single write. The latch copy captures the counter value from before the clear it is combined with.
- R8: Master-control bit 5 (master reset) does the following:
  - clears all control registers, the latch and the pointer;
  - sets the preset to FFFFFF;
  - issues one `cnt_mreset` pulse.

  All other bits of that write are ignored.
- R9: While `cs_n` is high, strobes have no effect on any register.
- R10: A falling edge on `ext_load_n` gives a `cnt_load` pulse when input-register bit 5 is 0. When that bit is 1, it copies `cnt_value` into the latch instead.
- R11: When input-register bit 4 is 0, a falling edge on `ext_clr_gate_n` gives a `cnt_clear` pulse and `count_en` equals input-register bit 3. When bit 4 is 1, the pin gives no pulse and `count_en` = bit 3 AND pin low.
- R12: `dout_oe` is high only while both `cs_n` and `rd_n` are low.
- R13: A master reset write and an `ext_load_n` latch load that land in the same cycle leave the latch at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_sel | input | 1 | 1 = control space, 0 = data space |
| din | input | 8 | Bus write data |
| dout | output | 8 | Bus read data, captured on each read |
| dout_oe | output | 1 | Bus output enable |
| ext_load_n | input | 1 | Active-low load pin (counter load or latch load) |
| ext_clr_gate_n | input | 1 | Active-low counter reset or count gate pin |
| cnt_value | input | 24 | Current counter value |
| cnt_flags | input | 5 | Counter flags {dir, sign, cmp, carry, borrow} |
| preset | output | 24 | Preset register |
| icr_q | output | 6 | Input control register |
| occr_q | output | 6 | Output/counter control register |
| qr_q | output | 2 | Quadrature mode register |
| count_en | output | 1 | Count inputs enabled |
| cnt_load | output | 1 | Pulse: load counter from preset |
| cnt_clear | output | 1 | Pulse: clear counter and its toggles |
| cmp_clear | output | 1 | Pulse: clear compare toggle |
| cnt_mreset | output | 1 | Pulse: master reset to the counter |

## Verification
A master reset write and a latch load from the external pin can reach the register block in the same cycle. To provoke this, the bench drops `wr_n` and `ext_load_n` on the same clock edge; both pass through synchronizers of equal depth, so they arrive together. The pin is set to latch-load mode beforehand, and the counter input holds a non-zero value. The outcome is judged by reading all three latch bytes back over the bus: every byte must be zero, showing that the master reset took precedence.

// File: rtl/cnt_host_pkg.sv
package cnt_host_pkg;

    localparam int FLAG_W  = 5;
    localparam int ICR_W   = 6;
    localparam int OCCR_W  = 6;
    localparam int QR_W    = 2;

    localparam int ICR_EN_BIT    = 3;
    localparam int ICR_GATE_BIT  = 4;
    localparam int ICR_LATCH_BIT = 5;

    typedef enum logic [1:0] {
        SEL_MASTER = 2'b00,
        SEL_INPUT  = 2'b01,
        SEL_OUTPUT = 2'b10,
        SEL_QUAD   = 2'b11
    } ctl_sel_e;

    typedef struct packed {
        logic mreset;
        logic cmp_clr;
        logic load;
        logic clear;
        logic snap;
        logic ptr_rst;
    } mcmd_t;

    typedef struct packed {
        logic dir;
        logic sign;
        logic cmp_tgl;
        logic carry_tgl;
        logic borrow_tgl;
    } flags_t;

    typedef struct packed {
        logic wr_ctl;
        logic wr_data;
        logic rd_ctl;
        logic rd_data;
        logic ld_fall;
        logic rg_fall;
    } access_t;

    function automatic ctl_sel_e ctl_target(input logic [1:0] top_bits);
        return ctl_sel_e'(top_bits);
    endfunction

endpackage

// File: rtl/cnt_host_sync.sv
module cnt_host_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/cnt_host_decode.sv
module cnt_host_decode
    import cnt_host_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    rd_n,
    input  logic    wr_n,
    input  logic    cd,
    input  logic    ld_n,
    input  logic    rg_n,
    output access_t acc,
    output logic    oe
);
    logic rd_p, wr_p, ld_p, rg_p;
    logic rd_f, wr_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= 1'b1;
            wr_p <= 1'b1;
            ld_p <= 1'b1;
            rg_p <= 1'b1;
        end else begin
            rd_p <= rd_n;
            wr_p <= wr_n;
            ld_p <= ld_n;
            rg_p <= rg_n;
        end
    end

    assign rd_f = rd_p & ~rd_n;
    assign wr_f = wr_p & ~wr_n;

    always_comb begin
        acc.wr_ctl  = wr_f & ~cs_n & cd;
        acc.wr_data = wr_f & ~cs_n & ~cd;
        acc.rd_ctl  = rd_f & ~cs_n & cd;
        acc.rd_data = rd_f & ~cs_n & ~cd;
        acc.ld_fall = ld_p & ~ld_n;
        acc.rg_fall = rg_p & ~rg_n;
    end

    assign oe = ~cs_n & ~rd_n;
endmodule

// File: rtl/cnt_host_regs.sv
module cnt_host_regs
    import cnt_host_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int CNT_W    = BYTE_W * NUM_BYTES,
    localparam int PTR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              rg_level,
    input  logic [CNT_W-1:0]  cnt_value,
    input  flags_t            flags,
    output logic [BYTE_W-1:0] dout,
    output logic [CNT_W-1:0]  preset,
    output logic [CNT_W-1:0]  latch,
    output logic [PTR_W-1:0]  ptr,
    output logic [ICR_W-1:0]  icr,
    output logic [OCCR_W-1:0] occr,
    output logic [QR_W-1:0]   qr,
    output logic              count_en,
    output logic              cnt_load,
    output logic              cnt_clear,
    output logic              cmp_clear,
    output logic              cnt_mreset
);
    mcmd_t             cmd;
    ctl_sel_e          sel;
    logic              mcr_hit;
    logic              do_mreset;
    logic [PTR_W-1:0]  ptr_next;
    logic [BYTE_W-1:0] latch_byte [NUM_BYTES];
    logic [BYTE_W-1:0] rd_byte;
    logic              snap_now;

    assign cmd       = mcmd_t'(data_i[5:0]);
    assign sel       = ctl_target(data_i[BYTE_W-1 -: 2]);
    assign mcr_hit   = acc.wr_ctl && (sel == SEL_MASTER);
    assign do_mreset = mcr_hit && cmd.mreset;
    assign ptr_next  = (ptr == PTR_W'(NUM_BYTES - 1)) ? '0 : ptr + 1'b1;
    assign snap_now  = (mcr_hit && cmd.snap) || (acc.ld_fall && icr[ICR_LATCH_BIT]);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        assign latch_byte[g] = latch[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < NUM_BYTES; b++) begin
            if (ptr == PTR_W'(b)) rd_byte = latch_byte[b];
        end
    end

    // shared byte pointer: reset has priority over advance
    always_ff @(posedge clk) begin
        if (rst || do_mreset) begin
            ptr <= '0;
        end else if (mcr_hit && cmd.ptr_rst) begin
            ptr <= '0;
        end else if (acc.wr_data || acc.rd_data) begin
            ptr <= ptr_next;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || do_mreset) begin
            preset <= '1;
        end else begin
            for (int b = 0; b < NUM_BYTES; b++) begin
                if (acc.wr_data && ptr == PTR_W'(b)) begin
                    preset[b*BYTE_W +: BYTE_W] <= data_i;
                end
            end
        end
    end

    // latch copies the counter value seen before any clear in the same write
    always_ff @(posedge clk) begin
        if (rst || do_mreset) begin
            latch <= '0;
        end else if (snap_now) begin
            latch <= cnt_value;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || do_mreset) begin
            icr  <= '0;
            occr <= '0;
            qr   <= '0;
        end else if (acc.wr_ctl) begin
            case (sel)
                SEL_INPUT:  icr  <= data_i[ICR_W-1:0];
                SEL_OUTPUT: occr <= data_i[OCCR_W-1:0];
                SEL_QUAD:   qr   <= data_i[QR_W-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_load   <= 1'b0;
            cnt_clear  <= 1'b0;
            cmp_clear  <= 1'b0;
            cnt_mreset <= 1'b0;
        end else begin
            cnt_load   <= !do_mreset && ((mcr_hit && cmd.load) ||
                                         (acc.ld_fall && !icr[ICR_LATCH_BIT]));
            cnt_clear  <= !do_mreset && ((mcr_hit && cmd.clear) ||
                                         (acc.rg_fall && !icr[ICR_GATE_BIT]));
            cmp_clear  <= !do_mreset && mcr_hit && cmd.cmp_clr;
            cnt_mreset <= do_mreset;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (acc.rd_ctl) begin
            dout <= {{(BYTE_W-FLAG_W){1'b0}}, flags};
        end else if (acc.rd_data) begin
            dout <= rd_byte;
        end
    end

    assign count_en = icr[ICR_EN_BIT] && (!icr[ICR_GATE_BIT] || !rg_level);
endmodule

// File: rtl/cnt_host_if.sv
module cnt_host_if
    import cnt_host_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int NUM_BYTES   = 3,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = BYTE_W * NUM_BYTES,
    localparam int SYNC_W     = BYTE_W + 6,
    localparam int PTR_W      = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              cd_sel,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout,
    output logic              dout_oe,
    input  logic              ext_load_n,
    input  logic              ext_clr_gate_n,
    input  logic [CNT_W-1:0]  cnt_value,
    input  logic [FLAG_W-1:0] cnt_flags,
    output logic [CNT_W-1:0]  preset,
    output logic [ICR_W-1:0]  icr_q,
    output logic [OCCR_W-1:0] occr_q,
    output logic [QR_W-1:0]   qr_q,
    output logic              count_en,
    output logic              cnt_load,
    output logic              cnt_clear,
    output logic              cmp_clear,
    output logic              cnt_mreset
);
    logic [SYNC_W-1:0] raw_bus, syn_bus;
    logic              cs_s, rd_s, wr_s, cd_s, ld_s, rg_s;
    logic [BYTE_W-1:0] data_s;
    access_t           acc;
    logic [CNT_W-1:0]  latch_q;
    logic [PTR_W-1:0]  ptr_q;

    assign raw_bus = {cs_n, rd_n, wr_n, cd_sel, ext_load_n, ext_clr_gate_n, din};
    assign {cs_s, rd_s, wr_s, cd_s, ld_s, rg_s, data_s} = syn_bus;

    cnt_host_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({SYNC_W{1'b1}})
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_bus),
        .q_o (syn_bus)
    );

    cnt_host_decode u_decode (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_s),
        .rd_n (rd_s),
        .wr_n (wr_s),
        .cd   (cd_s),
        .ld_n (ld_s),
        .rg_n (rg_s),
        .acc  (acc),
        .oe   (dout_oe)
    );

    cnt_host_regs #(
        .BYTE_W   (BYTE_W),
        .NUM_BYTES(NUM_BYTES)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .data_i    (data_s),
        .rg_level  (rg_s),
        .cnt_value (cnt_value),
        .flags     (flags_t'(cnt_flags)),
        .dout      (dout),
        .preset    (preset),
        .latch     (latch_q),
        .ptr       (ptr_q),
        .icr       (icr_q),
        .occr      (occr_q),
        .qr        (qr_q),
        .count_en  (count_en),
        .cnt_load  (cnt_load),
        .cnt_clear (cnt_clear),
        .cmp_clear (cmp_clear),
        .cnt_mreset(cnt_mreset)
    );
endmodule

// File: rtl/cnt_host_if_chk.sv
module cnt_host_if_chk #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    localparam int CNT_W    = BYTE_W * NUM_BYTES,
    localparam int PTR_W    = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              acc_wr_data,
    input logic              acc_rd_ctl,
    input logic [BYTE_W-1:0] data_s,
    input logic [PTR_W-1:0]  ptr,
    input logic [CNT_W-1:0]  latch,
    input logic [CNT_W-1:0]  preset,
    input logic [5:0]        icr_q,
    input logic [BYTE_W-1:0] dout,
    input logic [4:0]        cnt_flags,
    input logic              count_en,
    input logic              cnt_mreset
);
    a_r3_ptr_range: assert property (@(posedge clk) disable iff (rst)
        ptr < PTR_W'(NUM_BYTES));

    a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
        acc_wr_data |=> ptr == (($past(ptr) == PTR_W'(NUM_BYTES - 1)) ? '0 : $past(ptr) + 1'b1));

    a_r3_byte0_store: assert property (@(posedge clk) disable iff (rst)
        (acc_wr_data && ptr == '0) |=> preset[BYTE_W-1:0] == $past(data_s));

    a_r5_status_byte: assert property (@(posedge clk) disable iff (rst)
        acc_rd_ctl |=> dout == {{(BYTE_W-5){1'b0}}, $past(cnt_flags)});

    a_r8_mreset_state: assert property (@(posedge clk) disable iff (rst)
        cnt_mreset |-> (preset == '1 && latch == '0 && ptr == '0 && icr_q == '0));

    a_r11_gate_needs_enable: assert property (@(posedge clk) disable iff (rst)
        count_en |-> icr_q[3]);
endmodule

bind cnt_host_if cnt_host_if_chk #(
    .BYTE_W   (BYTE_W),
    .NUM_BYTES(NUM_BYTES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_wr_data(acc.wr_data),
    .acc_rd_ctl (acc.rd_ctl),
    .data_s     (data_s),
    .ptr        (ptr_q),
    .latch      (latch_q),
    .preset     (preset),
    .icr_q      (icr_q),
    .dout       (dout),
    .cnt_flags  (cnt_flags),
    .count_en   (count_en),
    .cnt_mreset (cnt_mreset)
);

// File: tb/cnt_host_if_bench.sv
`timescale 1ns/1ps
module cnt_host_if_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cd_sel = 1'b0;
    logic [7:0]  din = 8'h00;
    logic [7:0]  dout;
    logic        dout_oe;
    logic        ext_load_n = 1'b1, ext_clr_gate_n = 1'b1;
    logic [23:0] cnt_value = 24'h0;
    logic [4:0]  cnt_flags = 5'h0;
    logic [23:0] preset;
    logic [5:0]  icr_q, occr_q;
    logic [1:0]  qr_q;
    logic        count_en, cnt_load, cnt_clear, cmp_clear, cnt_mreset;

    int n_checks = 0;
    int n_err    = 0;
    int n_load = 0, n_clear = 0, n_cmp = 0, n_mrst = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cnt_host_if u_cnt_host_if (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .cd_sel(cd_sel), .din(din), .dout(dout), .dout_oe(dout_oe),
        .ext_load_n(ext_load_n), .ext_clr_gate_n(ext_clr_gate_n),
        .cnt_value(cnt_value), .cnt_flags(cnt_flags), .preset(preset),
        .icr_q(icr_q), .occr_q(occr_q), .qr_q(qr_q), .count_en(count_en),
        .cnt_load(cnt_load), .cnt_clear(cnt_clear), .cmp_clear(cmp_clear),
        .cnt_mreset(cnt_mreset)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (cnt_load)   n_load++;
            if (cnt_clear)  n_clear++;
            if (cmp_clear)  n_cmp++;
            if (cnt_mreset) n_mrst++;
        end
    end

    typedef struct packed {
        logic       rd;
        logic       cd;
        logic [7:0] val;
        logic [7:0] exp;
    } step_t;

    localparam int NSTEP = 9;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b0, 1'b1, 8'h01, 8'h00},
        '{1'b0, 1'b0, 8'h11, 8'h00},
        '{1'b0, 1'b0, 8'h22, 8'h00},
        '{1'b0, 1'b0, 8'h33, 8'h00},
        '{1'b0, 1'b1, 8'h02, 8'h00},
        '{1'b1, 1'b0, 8'h00, 8'hEF},
        '{1'b1, 1'b0, 8'h00, 8'hCD},
        '{1'b1, 1'b0, 8'h00, 8'hAB},
        '{1'b1, 1'b1, 8'h00, 8'h16}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic cd, input logic [7:0] v);
        @(negedge clk);
        cd_sel = cd; din = v; cs_n = 1'b0;
        idle(1);
        wr_n = 1'b0;
        idle(4);
        wr_n = 1'b1;
        idle(4);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic bus_read(input logic cd, output logic [7:0] v);
        @(negedge clk);
        cd_sel = cd; cs_n = 1'b0;
        idle(1);
        rd_n = 1'b0;
        idle(5);
        v = dout;
        check("R12 oe during read", {31'b0, dout_oe}, 32'h1);
        rd_n = 1'b1;
        idle(4);
        cs_n = 1'b1;
        idle(2);
    endtask

    task automatic pin_pulse(input bit which);
        @(negedge clk);
        if (which) ext_clr_gate_n = 1'b0; else ext_load_n = 1'b0;
        idle(5);
        ext_clr_gate_n = 1'b1; ext_load_n = 1'b1;
        idle(5);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: run did not finish (all requirements)");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rv;
        int l0, c0, m0, r0;
        idle(4);
        // R1 reset state
        check("R1 preset", preset, 32'hFFFFFF);
        check("R1 icr", icr_q, 0);
        check("R1 occr/qr", {occr_q, qr_q}, 0);
        check("R1 oe", dout_oe, 0);
        check("R1 pulses", {cnt_load, cnt_clear, cmp_clear, cnt_mreset}, 0);
        @(negedge clk); rst = 1'b0;
        idle(3);
        check("R1 pulses after release", n_load + n_clear + n_cmp + n_mrst, 0);

        // vector table: R3 preset fill, R6 snapshot, R4 latch reads, R5 status
        cnt_value = 24'hABCDEF;
        cnt_flags = 5'b10110;
        for (int i = 0; i < NSTEP; i++) begin
            if (STEPS[i].rd) begin
                bus_read(STEPS[i].cd, rv);
                check(STEPS[i].cd ? "R5 status byte" : "R4 latch byte", rv, STEPS[i].exp);
            end else begin
                bus_write(STEPS[i].cd, STEPS[i].val);
            end
        end
        check("R3 preset bytes", preset, 32'h332211);

        // R3 wrap: fourth write lands in byte 0
        bus_write(1, 8'h01);
        bus_write(0, 8'h11); bus_write(0, 8'h22); bus_write(0, 8'h33); bus_write(0, 8'h44);
        check("R3 pointer wrap", preset, 32'h332244);

        // R2 routing
        bus_write(1, 8'h40 | 8'h2A);
        check("R2 icr", icr_q, 6'h2A);
        bus_write(1, 8'h80 | 8'h15);
        check("R2 occr", occr_q, 6'h15);
        check("R2 icr kept", icr_q, 6'h2A);
        bus_write(1, 8'hC3);
        check("R2 qr", qr_q, 2'h3);
        check("R2 occr kept", occr_q, 6'h15);

        // R9 no effect without chip select
        @(negedge clk); cd_sel = 1'b0; din = 8'h99; cs_n = 1'b1;
        idle(1); wr_n = 1'b0; idle(4); wr_n = 1'b1; idle(4);
        @(negedge clk); cd_sel = 1'b1; din = 8'h7F;
        idle(1); wr_n = 1'b0; idle(4); wr_n = 1'b1; idle(4);
        check("R9 preset untouched", preset, 32'h332244);
        check("R9 icr untouched", icr_q, 6'h2A);

        // R6 single commands
        l0 = n_load; c0 = n_clear; m0 = n_cmp;
        bus_write(1, 8'h08);
        check("R6 load pulse", n_load - l0, 1);
        bus_write(1, 8'h04);
        check("R6 clear pulse", n_clear - c0, 1);
        bus_write(1, 8'h10);
        check("R6 compare clear pulse", n_cmp - m0, 1);

        // R7 combined commands in one write
        l0 = n_load; c0 = n_clear; m0 = n_cmp;
        bus_write(1, 8'h1C);
        check("R7 combined pulses", {n_load - l0, n_clear - c0, n_cmp - m0}, {32'd1, 32'd1, 32'd1});
        cnt_value = 24'h123456;
        bus_write(0, 8'h55);
        c0 = n_clear;
        bus_write(1, 8'h07);
        check("R7 clear with snapshot", n_clear - c0, 1);
        bus_read(0, rv); check("R7 latch byte0", rv, 8'h56);
        bus_read(0, rv); check("R7 latch byte1", rv, 8'h34);
        bus_read(0, rv); check("R7 latch byte2", rv, 8'h12);

        // R8 master reset with every other bit set
        l0 = n_load; c0 = n_clear; m0 = n_cmp; r0 = n_mrst;
        bus_write(1, 8'h3F);
        check("R8 mreset pulse", n_mrst - r0, 1);
        check("R8 others ignored", {n_load - l0, n_clear - c0, n_cmp - m0}, 0);
        check("R8 preset", preset, 32'hFFFFFF);
        check("R8 regs cleared", {icr_q, occr_q, qr_q}, 0);
        bus_read(0, rv); check("R8 latch cleared", rv, 8'h00);

        // R10 external load pin
        bus_write(1, 8'h48);
        l0 = n_load;
        pin_pulse(0);
        check("R10 pin counter load", n_load - l0, 1);
        bus_write(1, 8'h68);
        cnt_value = 24'hA1B2C3;
        l0 = n_load;
        pin_pulse(0);
        check("R10 no load in latch mode", n_load - l0, 0);
        bus_write(1, 8'h01);
        bus_read(0, rv); check("R10 latch byte0", rv, 8'hC3);
        bus_read(0, rv); check("R10 latch byte1", rv, 8'hB2);
        bus_read(0, rv); check("R10 latch byte2", rv, 8'hA1);

        // R11 reset mode then gate mode
        bus_write(1, 8'h48);
        check("R11 enable in reset mode", count_en, 1);
        c0 = n_clear;
        pin_pulse(1);
        check("R11 pin clear pulse", n_clear - c0, 1);
        bus_write(1, 8'h58);
        check("R11 gate closed pin high", count_en, 0);
        @(negedge clk); ext_clr_gate_n = 1'b0; idle(4);
        check("R11 gate open pin low", count_en, 1);
        @(negedge clk); ext_clr_gate_n = 1'b1; idle(4);
        check("R11 no pulse in gate mode", n_clear - c0, 1);

        // R12 output enable needs chip select
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; idle(5);
        check("R12 oe off without cs", dout_oe, 0);
        rd_n = 1'b1; idle(3);

        // R13 master reset and pin latch load in the same cycle
        bus_write(1, 8'h60);
        cnt_value = 24'h777777;
        @(negedge clk); cd_sel = 1'b1; din = 8'h20; cs_n = 1'b0;
        idle(1);
        wr_n = 1'b0; ext_load_n = 1'b0;
        idle(5);
        wr_n = 1'b1; ext_load_n = 1'b1;
        idle(4); cs_n = 1'b1; idle(2);
        bus_read(0, rv); check("R13 latch byte0", rv, 8'h00);
        bus_read(0, rv); check("R13 latch byte1", rv, 8'h00);
        bus_read(0, rv); check("R13 latch byte2", rv, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule